// File: doc/BRIEF.md
# Eight-Slot PRG Bank Mapper

This block translates the addresses of an 8-bit 6502-style CPU bus for a game cartridge. The upper 32 kB of the CPU map, 0x8000-0xFFFF, is divided into eight 4 kB slots. Each slot has its own 8-bit bank register, so any 4 kB bank of a PRG ROM of up to 1 MB can appear in any slot. The CPU loads a bank register by writing anywhere in 0x5000-0x5FFF. The low three address bits of that write pick the slot, and the data byte is the bank number.

On the video side, 8 kB of pattern memory is mapped flat, with no banking. A static strap selects horizontal or vertical nametable mirroring, and the block drives the matching nametable address bit. There is no PRG RAM, no interrupt logic and no software control of mirroring.

The only reset is a power-on reset. It is asserted asynchronously and released in step with the clock. It puts bank 0xFF in the top slot, where the reset vector lives, and bank 0x00 in every other slot. A CPU soft reset is not connected and leaves the banks as they are.

Top module: `prg_slot_mapper`

## Requirements
- R1: A CPU write with address bits 15..12 equal to 0101 (0x5000-0x5FFF) loads the bank register of the slot given by address bits 2..0. Address bits 11..3 have no influence on which slot is written.
- R2: Write cycles outside 0x5000-0x5FFF, and read cycles at any address, leave all bank registers unchanged.
- R3: During a read with address bit 15 set, prg_addr equals {bank of slot cpu_addr[14:12], cpu_addr[11:0]}.
- R4: A bank written on one clock edge is used by a read of that slot in the very next cycle.
- R5: After power-on reset, slot 7 holds 0xFF and slots 0 to 6 hold 0x00.
- R6: All eight data bits are stored, so every bank number from 0x00 to 0xFF can be selected.
- R7: prg_ce is 1 only for read cycles (cpu_we = 0) with cpu_addr[15] = 1. It is 0 for all writes and for all reads below 0x8000.
- R8: chr_addr always equals ppu_addr, the 13-bit pattern address passed through without change.
- R9: ntb_sel equals ppu_addr[10] when mirror_vert = 1 (vertical) and ppu_addr[11] when mirror_vert = 0 (horizontal).
- R10: While por_n is low, the R5 values are forced and writes have no effect. After por_n rises, a write ending on the second rising edge is still ignored, and writes are accepted from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; a write takes effect on its rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video address bits 12..0 |
| mirror_vert | input | 1 | Mirroring strap: 1 = vertical, 0 = horizontal |
| prg_addr | output | 20 | PRG ROM address |
| prg_ce | output | 1 | PRG ROM enable for upper-window reads |
| chr_addr | output | 13 | Pattern memory address |
| ntb_sel | output | 1 | Nametable select bit |

## Verification
On every cycle, the assertions check the following:
- a bank written in one cycle shows up on a read of that slot in the next;
- a slot's bank holds when no register write occurs between two reads of it;
- the ROM enable is tied to read cycles;
- the offset, pattern address and nametable bit follow their address inputs.

Only the bench scenarios can show the power-on values, the cycle on which writes start to be accepted after reset, and the absence of crosstalk between slots. They also show that every one of the 256 bank values is reachable through writes with varied don't-care address bits.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int unsigned SLOTS_DEF  = 8;
  localparam int unsigned BANK_W_DEF = 8;
  localparam int unsigned OFS_W_DEF  = 12;
  localparam int unsigned CPU_AW_DEF = 16;
  localparam int unsigned CHR_AW_DEF = 13;
  localparam logic [3:0]  WIN_NIB_DEF = 4'h5;

  typedef enum logic {
    MIR_HORZ = 1'b0,
    MIR_VERT = 1'b1
  } mirror_e;
endpackage

// File: rtl/mapper_rst_sync.sv
module mapper_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/mapper_cpu_decode.sv
module mapper_cpu_decode #(
  parameter int unsigned CPU_AW  = 16,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned SLOT_W  = 3,
  parameter logic [3:0]  WIN_NIB = 4'h5
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  output logic              reg_wr,
  output logic [SLOT_W-1:0] reg_slot,
  output logic              rom_rd,
  output logic [SLOT_W-1:0] rom_slot,
  output logic [OFS_W-1:0]  rom_ofs
);
  // register window: coarse nibble decode, slot from the lowest bits
  always_comb begin
    reg_wr   = cpu_we && (cpu_addr[CPU_AW-1 -: 4] == WIN_NIB);
    reg_slot = cpu_addr[SLOT_W-1:0];
    rom_rd   = !cpu_we && cpu_addr[CPU_AW-1];
    rom_slot = cpu_addr[OFS_W +: SLOT_W];
    rom_ofs  = cpu_addr[OFS_W-1:0];
  end
endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned BANK_W = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [BANK_W-1:0] rd_bank
);
  logic [BANK_W-1:0] bank_q [SLOTS];
  logic [BANK_W-1:0] bank_d [SLOTS];
  logic [SLOTS-1:0]  slot_we;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    // top slot starts on the last bank so the reset vector is mapped
    localparam logic [BANK_W-1:0] RST_VAL =
      (g == SLOTS - 1) ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

    always_comb begin
      slot_we[g] = wr_en && (wr_slot == SLOT_W'(g));
      bank_d[g]  = slot_we[g] ? wr_data : bank_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= RST_VAL;
      else        bank_q[g] <= bank_d[g];
    end
  end

  assign rd_bank = bank_q[rd_slot];
endmodule

// File: rtl/mapper_ppu_map.sv
module mapper_ppu_map
  import prg_map_pkg::*;
#(
  parameter int unsigned CHR_AW = 13
) (
  input  logic [CHR_AW-1:0] ppu_addr,
  input  mirror_e           mirror,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              ntb_sel
);
  always_comb begin
    chr_addr = ppu_addr;
    ntb_sel  = (mirror == MIR_VERT) ? ppu_addr[10] : ppu_addr[11];
  end
endmodule

// File: rtl/prg_slot_mapper.sv
module prg_slot_mapper
  import prg_map_pkg::*;
#(
  parameter int unsigned SLOTS   = SLOTS_DEF,
  parameter int unsigned BANK_W  = BANK_W_DEF,
  parameter int unsigned OFS_W   = OFS_W_DEF,
  parameter int unsigned CHR_AW  = CHR_AW_DEF,
  parameter logic [3:0]  WIN_NIB = WIN_NIB_DEF,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned CPU_AW = 1 + SLOT_W + OFS_W,
  localparam int unsigned PRG_AW = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [BANK_W-1:0] cpu_wdata,
  input  logic [CHR_AW-1:0] ppu_addr,
  input  logic              mirror_vert,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_ce,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              ntb_sel
);
  logic              rst_q_n;
  logic              reg_wr;
  logic [SLOT_W-1:0] reg_slot;
  logic              rom_rd;
  logic [SLOT_W-1:0] rom_slot;
  logic [OFS_W-1:0]  rom_ofs;
  logic [BANK_W-1:0] rom_bank;
  mirror_e           mirror;

  mapper_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_q_n)
  );

  mapper_cpu_decode #(
    .CPU_AW  (CPU_AW),
    .OFS_W   (OFS_W),
    .SLOT_W  (SLOT_W),
    .WIN_NIB (WIN_NIB)
  ) u_dec (
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .reg_wr   (reg_wr),
    .reg_slot (reg_slot),
    .rom_rd   (rom_rd),
    .rom_slot (rom_slot),
    .rom_ofs  (rom_ofs)
  );

  mapper_bank_regs #(
    .SLOTS  (SLOTS),
    .BANK_W (BANK_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (reg_wr),
    .wr_slot (reg_slot),
    .wr_data (cpu_wdata),
    .rd_slot (rom_slot),
    .rd_bank (rom_bank)
  );

  assign mirror = mirror_vert ? MIR_VERT : MIR_HORZ;

  mapper_ppu_map #(.CHR_AW(CHR_AW)) u_ppu (
    .ppu_addr (ppu_addr),
    .mirror   (mirror),
    .chr_addr (chr_addr),
    .ntb_sel  (ntb_sel)
  );

  assign prg_addr = {rom_bank, rom_ofs};
  assign prg_ce   = rom_rd;
endmodule

// File: rtl/prg_slot_mapper_chk.sv
module prg_slot_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_we,
  input logic [7:0]  cpu_wdata,
  input logic [12:0] ppu_addr,
  input logic        mirror_vert,
  input logic [19:0] prg_addr,
  input logic        prg_ce,
  input logic [12:0] chr_addr,
  input logic        ntb_sel
);
  logic armed_q;
  logic win_wr;
  logic hi_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign win_wr = cpu_we && (cpu_addr[15:12] == 4'h5);
  assign hi_rd  = !cpu_we && cpu_addr[15];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(win_wr) && hi_rd && (cpu_addr[14:12] == $past(cpu_addr[2:0])))
    |-> (prg_addr[19:12] == $past(cpu_wdata))); // R4

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(win_wr) && $past(hi_rd) && hi_rd &&
     (cpu_addr[14:12] == $past(cpu_addr[14:12])))
    |-> (prg_addr[19:12] == $past(prg_addr[19:12]))); // R2

  AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    prg_ce |-> (prg_addr[11:0] == cpu_addr[11:0])); // R3

  AST_CE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we || !cpu_addr[15]) |-> !prg_ce); // R7

  AST_CHR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr == ppu_addr); // R8

  AST_NTB_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ntb_sel == (mirror_vert ? ppu_addr[10] : ppu_addr[11])); // R9
endmodule

bind prg_slot_mapper prg_slot_mapper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .cpu_addr    (cpu_addr),
  .cpu_we      (cpu_we),
  .cpu_wdata   (cpu_wdata),
  .ppu_addr    (ppu_addr),
  .mirror_vert (mirror_vert),
  .prg_addr    (prg_addr),
  .prg_ce      (prg_ce),
  .chr_addr    (chr_addr),
  .ntb_sel     (ntb_sel)
);

// File: tb/prg_slot_mapper_tb.sv
module prg_slot_mapper_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        por_n;
  logic [15:0] cpu_addr;
  logic        cpu_we;
  logic [7:0]  cpu_wdata;
  logic [12:0] ppu_addr;
  logic        mirror_vert;
  logic [19:0] prg_addr;
  logic        prg_ce;
  logic [12:0] chr_addr;
  logic        ntb_sel;

  int total = 0;
  int bad   = 0;
  logic [7:0] mdl [8];

  always #(CLK_P/2) clk = ~clk;

  prg_slot_mapper u_dut (
    .clk (clk), .por_n (por_n), .cpu_addr (cpu_addr), .cpu_we (cpu_we),
    .cpu_wdata (cpu_wdata), .ppu_addr (ppu_addr), .mirror_vert (mirror_vert),
    .prg_addr (prg_addr), .prg_ce (prg_ce), .chr_addr (chr_addr), .ntb_sel (ntb_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [11:0] ofs, input string req);
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = {1'b1, s, ofs}; cpu_wdata = 8'h5A;
    #1;
    chk(req, {12'h0, prg_addr}, {12'h0, mdl[s], ofs});
    chk({req, " ce"}, {31'h0, prg_ce}, 32'h1);
  endtask

  task automatic reset_model();
    for (int i = 0; i < 8; i++) mdl[i] = (i == 7) ? 8'hFF : 8'h00;
  endtask

  task automatic all_slots(input string req, input logic [11:0] ofs);
    for (int i = 0; i < 8; i++) rd_chk(3'(i), ofs, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00;
    ppu_addr = '0; mirror_vert = 1'b0;
    #1 por_n = 1'b0;
    reset_model();
    repeat (2) @(posedge clk);

    // R5: power-on contents
    all_slots("R5 power-on", 12'h000);
    all_slots("R5 power-on", 12'hFFC);

    // R10: write while reset held is ignored
    wr(16'h5FF8, 8'h12);
    rd_chk(3'd0, 12'h010, "R10 write in reset");

    // R10: release timing
    @(negedge clk); cpu_we = 1'b0; por_n = 1'b1;
    wr(16'h5000, 8'h33);      // ends on 2nd edge: ignored
    wr(16'h5001, 8'h44);      // ends on 3rd edge: accepted
    mdl[1] = 8'h44;
    rd_chk(3'd0, 12'h020, "R10 second edge ignored");
    rd_chk(3'd1, 12'h020, "R10 third edge accepted");

    // R1 R4 R6: every bank value, varied don't-care bits, read right after
    for (int d = 0; d < 256; d++) begin
      logic [2:0]  s;
      logic [8:0]  junk;
      s    = 3'(d) ^ 3'(d >> 3);
      junk = 9'((d * 37) & 9'h1FF);
      wr({4'h5, junk, s}, 8'(d));
      mdl[s] = 8'(d);
      rd_chk(s, 12'((d * 13) & 12'hFFF), "R4 R6 R1 next-cycle read");
    end

    // R3 R1: every slot, edge offsets, no crosstalk
    all_slots("R3 R1 sweep", 12'h000);
    all_slots("R3 R1 sweep", 12'hFFF);
    all_slots("R3 R1 sweep", 12'hA5C);

    // R2: writes outside window and reads inside window
    for (int s = 0; s < 8; s++) begin
      wr(16'h4FF8 + 16'(s), 8'hC3);
      wr(16'h6000 + 16'(s), 8'hC3);
      wr(16'hD000 + 16'(s), 8'hC3);
      wr(16'h0000 + 16'(s), 8'hC3);
      @(negedge clk); cpu_we = 1'b0; cpu_addr = 16'h5FF8 + 16'(s); cpu_wdata = 8'hC3;
    end
    all_slots("R2 ignored access", 12'h123);

    // R7: chip enable over every upper nibble, read and write
    for (int n = 0; n < 16; n++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        cpu_we = w[0]; cpu_addr = {4'(n), 12'h123}; cpu_wdata = mdl[3];
        #1;
        chk("R7 ce", {31'h0, prg_ce}, {31'h0, (w == 0) && (n >= 8)});
      end
    end
    all_slots("R7 banks untouched", 12'h777);

    // R8 R9: exhaustive video address, both straps
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8192; i++) begin
        logic [12:0] pa;
        pa = 13'(i);
        ppu_addr = pa; mirror_vert = m[0];
        #1;
        chk("R8 chr pass", {19'h0, chr_addr}, {19'h0, pa});
        chk("R9 nametable", {31'h0, ntb_sel}, {31'h0, (m == 1) ? pa[10] : pa[11]});
      end
    end

    // R10 R5: reset in mid-run restores defaults
    @(negedge clk); cpu_we = 1'b0; por_n = 1'b0;
    reset_model();
    #1;
    all_slots("R10 R5 re-reset", 12'h0AB);
    @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(16'h5AB7, 8'h5E);
    mdl[7] = 8'h5E;
    rd_chk(3'd7, 12'hFFE, "R4 after re-reset");
    all_slots("R1 after re-reset", 12'h400);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule